// File: doc/BRIEF.md
# Cascaded Event Interrupt Aggregator

This block gathers single-cycle event pulses from many sources into three pending words of `WORD_W` bits each and turns them into three level-sensitive interrupt lines. Each line has one mask word per pending word. A line is high while at least one pending bit is set and its mask bit for that line is also set. An event is named by a number. The two bits above the bit-index field pick the pending word, and the low bits pick the bit inside that word. A second pulse input clears one event by number in the same way.

The first pending word also holds the summary for the other two. Its bit `WORD_W-2` goes high when anything lands in the middle word, and its bit `WORD_W-1` goes high when anything lands in the high word. Software reaches the pending and mask words through a flat register port with a combinational read. Each pending word has its own write rule. Writing the first word clears the bits written as 1, but a write never touches the two summary bits. Writes to the middle word have no effect. Writing the high word clears the bits written as 1, and when that leaves the high word empty its summary bit drops as well. An event-number clear that leaves the middle or high word empty drops the matching summary bit too. Outputs follow from registered state, so every change shows on the outputs one clock after the edge that caused it.

Top module: `evt_irq_agg`

## Requirements
- R1: A set pulse with event number bits [6:5] = w (0, 1 or 2) and bits [4:0] = b makes bit b of pending word w read 1 after the next clock edge.
- R2: A set or clear pulse whose word field is 3 changes no pending word.
- R3: Setting any bit of pending word 1 also sets bit 30 of word 0, and setting any bit of word 2 also sets bit 31 of word 0, in the same edge.
- R4: Output bit k of `irq_out` (bit 0 = line A, 1 = B, 2 = C) is 1 exactly when some pending word w has a bit that is 1 both there and in mask word (k, w), evaluated on the registered state.
- R5: A register write to pending word 0 clears every bit written as 1, except bits 31 and 30, which keep their value.
- R6: A register write to pending word 1 leaves every pending word unchanged.
- R7: A register write to pending word 2 clears the bits written as 1. If word 2 is then zero, bit 31 of word 0 is cleared in the same edge.
- R8: A clear pulse clears one pending bit. If it targets word 1 or word 2 and that word is zero afterwards, bit 30 (word 1) or bit 31 (word 0 for word 2) of word 0 is cleared in the same edge.
- R9: A mask write stores the full written word, and all three outputs follow the new masks one edge later. An output can rise or fall because of a mask write.
- R10: Synchronous active-low reset zeroes all pending and mask words and holds all outputs low.
- R11: When a set and a clear apply to the same bit in one cycle, the bit ends up set, and so does its summary bit.
- R12: Register address a[1:0] is the word and a[3:2] is the group. Group 0 holds the pending words, and group k+1 holds the mask words of output k. Word 3 of any group reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set_vld | input | 1 | Set pulse for the event named by `evt_set_num` |
| evt_set_num | input | 7 | Event number to set: word in [6:5], bit in [4:0] |
| evt_clr_vld | input | 1 | Clear pulse for the event named by `evt_clr_num` |
| evt_clr_num | input | 7 | Event number to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (group in [3:2], word in [1:0]) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 3 | Level interrupt lines A, B, C |

## Verification
The bench uses the default parameters: 32-bit words and three outputs. With these, the event number is 7 bits wide, so the unused word code 3 can be driven, and the two summary bits sit at positions 31 and 30. The register map fills four address groups, and one unused word slot in each group can be probed. Random traffic mixes sets, clears, pending writes and sparse mask writes at these sizes. This often clears a word to empty in the same cycle that a set lands in the summary bit or in the same word, which tests the set-wins and cascade-clear orderings.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the event interrupt aggregator.
// Assumes exactly three pending words; the cascade rules name them.
package evt_irq_pkg;
    localparam int NUM_WORDS = 3;
    localparam int W_MAIN    = 0;   // word holding the summary bits
    localparam int W_MID     = 1;   // read-only word, summary at WORD_W-2
    localparam int W_HIGH    = 2;   // clearable word, summary at WORD_W-1
    localparam int GRP_PEND  = 0;   // address group of the pending words
endpackage

// File: rtl/evt_irq_decode.sv
// Turns a valid event number into a one-hot hit per pending word.
// Assumes the word field sits directly above the bit-index field;
// a word code beyond the last pending word produces no hit.
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int SEL_LSB = $clog2(WORD_W),
    localparam int EVT_W   = SEL_LSB + 2
) (
    input  logic                                 vld,
    input  logic [EVT_W-1:0]                     num,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]     hit
);
    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    logic [1:0]         word_sel;
    logic [SEL_LSB-1:0] bit_sel;

    assign word_sel = num[EVT_W-1:SEL_LSB];
    assign bit_sel  = num[SEL_LSB-1:0];

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            // One-hot hit when this word is selected by a valid pulse
            always_comb begin
                if (vld && (word_sel == 2'(w)))
                    hit[w] = ONE << bit_sel;
                else
                    hit[w] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/evt_irq_pending.sv
// Pending word storage with per-word clear rules and cascade summary bits.
// Assumes set hits win over every clear source in the same cycle and
// that summary bits live in the top two bits of the main word.
module evt_irq_pending
    import evt_irq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] set_hit,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] clr_hit,
    input  logic                             wr_main,
    input  logic                             wr_high,
    input  logic [WORD_W-1:0]                wdata,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] pend
);
    localparam logic [WORD_W-1:0] SUM_BITS = {2'b11, {(WORD_W-2){1'b0}}};

    logic [NUM_WORDS-1:0][WORD_W-1:0] reg_clr;
    logic [NUM_WORDS-1:0][WORD_W-1:0] after_clr;
    logic [NUM_WORDS-1:0][WORD_W-1:0] with_set;
    logic [NUM_WORDS-1:0][WORD_W-1:0] pend_nxt;
    logic                             drop_mid;
    logic                             drop_high;
    logic [WORD_W-1:0]                sum_clr;
    logic [WORD_W-1:0]                sum_set;

    // Register-write clear masks: main word spares the summary bits
    always_comb begin
        reg_clr[W_MAIN] = wr_main ? (wdata & ~SUM_BITS) : '0;
        reg_clr[W_MID]  = '0;
        reg_clr[W_HIGH] = wr_high ? wdata : '0;
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_clr
            // Apply all clears, then the sets on top of them
            always_comb begin
                after_clr[w] = pend[w] & ~(clr_hit[w] | reg_clr[w]);
                with_set[w]  = after_clr[w] | set_hit[w];
            end
        end
    endgenerate

    // Summary drops when a clear leaves its word empty
    always_comb begin
        drop_mid  = (|clr_hit[W_MID]) && (with_set[W_MID] == '0);
        drop_high = ((|clr_hit[W_HIGH]) || wr_high) && (with_set[W_HIGH] == '0);
        sum_clr   = {drop_high, drop_mid, {(WORD_W-2){1'b0}}};
        sum_set   = {(|set_hit[W_HIGH]), (|set_hit[W_MID]), {(WORD_W-2){1'b0}}};
    end

    // Next value of every word; sets and summary sets win
    always_comb begin
        pend_nxt[W_MID]  = with_set[W_MID];
        pend_nxt[W_HIGH] = with_set[W_HIGH];
        pend_nxt[W_MAIN] = (after_clr[W_MAIN] & ~sum_clr) | set_hit[W_MAIN] | sum_set;
    end

    // Pending state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end
endmodule

// File: rtl/evt_irq_masks.sv
// Mask word storage: one mask word per output and pending word.
// Assumes the write strobes are already decoded one-hot by address.
module evt_irq_masks
    import evt_irq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_IRQ = 3
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [NUM_IRQ-1:0][NUM_WORDS-1:0]              wr,
    input  logic [WORD_W-1:0]                              wdata,
    output logic [NUM_IRQ-1:0][NUM_WORDS-1:0][WORD_W-1:0]  mask
);
    genvar k, w;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_irq
            for (w = 0; w < NUM_WORDS; w++) begin : g_word
                // Store the whole word on its strobe
                always_ff @(posedge clk) begin
                    if (!rst_n)       mask[k][w] <= '0;
                    else if (wr[k][w]) mask[k][w] <= wdata;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/evt_irq_reduce.sv
// Combines pending and mask words into one level line per output.
// Assumes both inputs are registered, so the lines carry no glitch
// from the event inputs.
module evt_irq_reduce
    import evt_irq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_IRQ = 3
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]               pend,
    input  logic [NUM_IRQ-1:0][NUM_WORDS-1:0][WORD_W-1:0]  mask,
    output logic [NUM_IRQ-1:0]                             irq
);
    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_irq
            // OR of every enabled pending bit across all words
            always_comb begin
                irq[k] = 1'b0;
                for (int w = 0; w < NUM_WORDS; w++)
                    irq[k] = irq[k] | (|(pend[w] & mask[k][w]));
            end
        end
    endgenerate
endmodule

// File: rtl/evt_irq_agg.sv
// Top of the event interrupt aggregator: decodes event pulses and
// register accesses, holds pending and mask words, drives the lines.
// Assumes address groups of four words; word slot 3 is unmapped.
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_IRQ = 3,
    localparam int SEL_LSB = $clog2(WORD_W),
    localparam int EVT_W   = SEL_LSB + 2,
    localparam int GRP_W   = $clog2(NUM_IRQ + 1),
    localparam int ADDR_W  = GRP_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_set_vld,
    input  logic [EVT_W-1:0]   evt_set_num,
    input  logic               evt_clr_vld,
    input  logic [EVT_W-1:0]   evt_clr_num,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_IRQ-1:0] irq_out
);
    logic [NUM_WORDS-1:0][WORD_W-1:0]              set_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0]              clr_hit;
    logic [NUM_WORDS-1:0][WORD_W-1:0]              pend;
    logic [NUM_IRQ-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask;
    logic [NUM_IRQ-1:0][NUM_WORDS-1:0]             mask_wr;
    logic [GRP_W-1:0]                              grp;
    logic [1:0]                                    word;
    logic                                          wr_main;
    logic                                          wr_high;

    assign grp  = reg_addr[ADDR_W-1:2];
    assign word = reg_addr[1:0];

    // Pending-word write strobes; the middle word has none
    always_comb begin
        wr_main = reg_wr && (grp == GRP_W'(GRP_PEND)) && (word == 2'(W_MAIN));
        wr_high = reg_wr && (grp == GRP_W'(GRP_PEND)) && (word == 2'(W_HIGH));
    end

    // Mask write strobes, one per output and word
    always_comb begin
        for (int k = 0; k < NUM_IRQ; k++)
            for (int w = 0; w < NUM_WORDS; w++)
                mask_wr[k][w] = reg_wr && (grp == GRP_W'(k + 1)) && (word == 2'(w));
    end

    // Combinational read mux over pending and mask words
    always_comb begin
        reg_rdata = '0;
        if (word < 2'(NUM_WORDS)) begin
            if (grp == GRP_W'(GRP_PEND))
                reg_rdata = pend[word];
            else
                for (int k = 0; k < NUM_IRQ; k++)
                    if (grp == GRP_W'(k + 1))
                        reg_rdata = mask[k][word];
        end
    end

    evt_irq_decode #(.WORD_W(WORD_W)) u_set_dec (
        .vld (evt_set_vld),
        .num (evt_set_num),
        .hit (set_hit)
    );

    evt_irq_decode #(.WORD_W(WORD_W)) u_clr_dec (
        .vld (evt_clr_vld),
        .num (evt_clr_num),
        .hit (clr_hit)
    );

    evt_irq_pending #(.WORD_W(WORD_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .wr_main (wr_main),
        .wr_high (wr_high),
        .wdata   (reg_wdata),
        .pend    (pend)
    );

    evt_irq_masks #(.WORD_W(WORD_W), .NUM_IRQ(NUM_IRQ)) u_masks (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mask_wr),
        .wdata (reg_wdata),
        .mask  (mask)
    );

    evt_irq_reduce #(.WORD_W(WORD_W), .NUM_IRQ(NUM_IRQ)) u_reduce (
        .pend (pend),
        .mask (mask),
        .irq  (irq_out)
    );
endmodule

// File: rtl/evt_irq_agg_chk.sv
// Property checker for the event interrupt aggregator, bound to the top.
// Assumes the pending and mask state of the top are visible by name.
module evt_irq_agg_chk
    import evt_irq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_IRQ = 3,
    localparam int SEL_LSB = $clog2(WORD_W),
    localparam int EVT_W   = SEL_LSB + 2,
    localparam int GRP_W   = $clog2(NUM_IRQ + 1),
    localparam int ADDR_W  = GRP_W + 2
) (
    input logic                                          clk,
    input logic                                          rst_n,
    input logic                                          evt_set_vld,
    input logic [EVT_W-1:0]                              evt_set_num,
    input logic                                          evt_clr_vld,
    input logic [EVT_W-1:0]                              evt_clr_num,
    input logic                                          reg_wr,
    input logic [ADDR_W-1:0]                             reg_addr,
    input logic [NUM_IRQ-1:0]                            irq_out,
    input logic [NUM_WORDS-1:0][WORD_W-1:0]              pend,
    input logic [NUM_IRQ-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask
);
    logic [1:0]         sw;
    logic [SEL_LSB-1:0] sb;
    logic               set_ok;
    logic               wr_p0;
    logic               wr_p1;
    logic               wr_p2;

    assign sw     = evt_set_num[EVT_W-1:SEL_LSB];
    assign sb     = evt_set_num[SEL_LSB-1:0];
    assign set_ok = evt_set_vld && (sw < 2'(NUM_WORDS));
    assign wr_p0  = reg_wr && (reg_addr == ADDR_W'(0));
    assign wr_p1  = reg_wr && (reg_addr == ADDR_W'(1));
    assign wr_p2  = reg_wr && (reg_addr == ADDR_W'(2));

    // First cycle out of reset: everything empty and quiet
    assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend == '0 && mask == '0 && irq_out == '0));

    // A set in the middle or high word raises its summary bit
    assert_cascade_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && sw == 2'(W_MID)) |=> pend[W_MAIN][WORD_W-2]);
    assert_cascade_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && sw == 2'(W_HIGH)) |=> pend[W_MAIN][WORD_W-1]);

    // A write to the middle word alone leaves all pending words as they were
    assert_mid_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_p1 && !evt_set_vld && !evt_clr_vld) |=> $stable(pend));

    // A write to the main word never drops a summary bit
    assert_summary_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_p0 && !evt_clr_vld) |=>
        ((pend[W_MAIN][WORD_W-1:WORD_W-2] & $past(pend[W_MAIN][WORD_W-1:WORD_W-2]))
         == $past(pend[W_MAIN][WORD_W-1:WORD_W-2])));

    // A write that empties the high word drops its summary bit
    assert_high_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_p2 && !evt_set_vld) |=> (pend[W_HIGH] != '0 || !pend[W_MAIN][WORD_W-1]));

    // Set beats a simultaneous clear of the same bit
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && evt_clr_vld && evt_clr_num == evt_set_num) |=> pend[$past(sw)][$past(sb)]);

    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_irq
            // An enabled set with masks held drives the line high
            assert_enabled_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (set_ok && !reg_wr && mask[k][sw][sb]) |=> irq_out[k]);
        end
    endgenerate
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.WORD_W(WORD_W), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_set_vld (evt_set_vld),
    .evt_set_num (evt_set_num),
    .evt_clr_vld (evt_clr_vld),
    .evt_clr_num (evt_clr_num),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .irq_out     (irq_out),
    .pend        (pend),
    .mask        (mask)
);

// File: tb/tb_evt_irq_agg.sv
`timescale 1ns/1ps
module tb_evt_irq_agg;
    localparam int WORD_W = 32;
    localparam int NIRQ   = 3;
    localparam int EVT_W  = 7;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              evt_set_vld;
    logic [EVT_W-1:0]  evt_set_num;
    logic              evt_clr_vld;
    logic [EVT_W-1:0]  evt_clr_num;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [WORD_W-1:0] reg_wdata;
    logic [WORD_W-1:0] reg_rdata;
    logic [NIRQ-1:0]   irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_pend [3];
    logic [31:0] m_mask [3][3];
    logic [31:0] n_pend [3];
    logic [31:0] n_mask [3][3];

    always #10 clk = ~clk;

    evt_irq_agg dut (
        .clk(clk), .rst_n(rst_n),
        .evt_set_vld(evt_set_vld), .evt_set_num(evt_set_num),
        .evt_clr_vld(evt_clr_vld), .evt_clr_num(evt_clr_num),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_irq();
        logic [2:0] r = '0;
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 3; w++)
                if ((m_pend[w] & m_mask[k][w]) != 0) r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_reg(logic [3:0] a);
        if (a[1:0] == 2'd3) return '0;
        if (a[3:2] == 2'd0) return m_pend[a[1:0]];
        return m_mask[a[3:2] - 2'd1][a[1:0]];
    endfunction

    // Next model state from the current inputs, written from R1-style rules
    task automatic model_next();
        int sw, sb, cw, cb;
        bit clr_mid, clr_high;
        for (int w = 0; w < 3; w++) n_pend[w] = m_pend[w];
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 3; w++) n_mask[k][w] = m_mask[k][w];
        clr_mid = 0; clr_high = 0;
        if (reg_wr && reg_addr == 4'd0) n_pend[0] = n_pend[0] & ~(reg_wdata & 32'h3FFF_FFFF);
        if (reg_wr && reg_addr == 4'd2) begin n_pend[2] = n_pend[2] & ~reg_wdata; clr_high = 1; end
        if (reg_wr && reg_addr[3:2] != 0 && reg_addr[1:0] != 3)
            n_mask[reg_addr[3:2]-1][reg_addr[1:0]] = reg_wdata;
        cw = evt_clr_num[6:5]; cb = evt_clr_num[4:0];
        if (evt_clr_vld && cw < 3) begin
            n_pend[cw][cb] = 1'b0;
            if (cw == 1) clr_mid = 1;
            if (cw == 2) clr_high = 1;
        end
        sw = evt_set_num[6:5]; sb = evt_set_num[4:0];
        if (evt_set_vld && sw >= 1 && sw < 3) n_pend[sw][sb] = 1'b1;
        if (clr_mid && n_pend[1] == 0) n_pend[0][30] = 1'b0;
        if (clr_high && n_pend[2] == 0) n_pend[0][31] = 1'b0;
        if (evt_set_vld && sw < 3) begin
            n_pend[sw][sb] = 1'b1;
            if (sw == 1) n_pend[0][30] = 1'b1;
            if (sw == 2) n_pend[0][31] = 1'b1;
        end
    endtask

    task automatic idle();
        evt_set_vld = 0; evt_set_num = '0;
        evt_clr_vld = 0; evt_clr_num = '0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    // One clock: predict, clock, commit, compare the lines (R4)
    task automatic step(string req);
        model_next();
        @(posedge clk); #2;
        for (int w = 0; w < 3; w++) m_pend[w] = n_pend[w];
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 3; w++) m_mask[k][w] = n_mask[k][w];
        idle();
        check({req, " R4 irq"}, 32'(irq_out), 32'(exp_irq()));
    endtask

    task automatic read_all(string req);
        reg_wr = 0;
        for (int a = 0; a < 16; a++) begin
            reg_addr = 4'(a); #1;
            check(req, reg_rdata, exp_reg(4'(a)));
        end
        reg_addr = '0;
    endtask

    task automatic ev_set(int n);  evt_set_vld = 1; evt_set_num = 7'(n); endtask
    task automatic ev_clr(int n);  evt_clr_vld = 1; evt_clr_num = 7'(n); endtask
    task automatic wr(int a, logic [31:0] d); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d; endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        for (int w = 0; w < 3; w++) m_pend[w] = '0;
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 3; w++) m_mask[k][w] = '0;
        repeat (3) @(posedge clk); #2;
        read_all("R10 reset registers");
        check("R10 reset irq", 32'(irq_out), 32'd0);
        rst_n = 1;

        // R1: word 0 bit 5
        ev_set(5); step("R1");
        check("R1 word0 bit5", m_pend[0], 32'h20); read_all("R1 readback");
        // R3: middle and high words raise summary bits
        ev_set(32 + 7); step("R3");
        ev_set(64 + 31); step("R3");
        check("R3 summary bits", {m_pend[0][31:30], 30'd0}, 32'hC000_0000);
        read_all("R3 readback");
        // R2: word code 3 changes nothing
        ev_set(96 + 3); step("R2");
        ev_clr(96 + 5); step("R2");
        read_all("R2 no change");
        // R9: mask rises then falls
        wr(4 + 1, 32'h80); step("R9 rise");
        check("R9 line A high", 32'(irq_out), 32'h1);
        wr(4 + 1, 32'h0); step("R9 fall");
        check("R9 line A low", 32'(irq_out), 32'h0);
        wr(12 + 2, 32'h8000_0000); step("R9 line C");
        check("R9 line C high", 32'(irq_out), 32'h4);
        // R6: middle word ignores writes
        wr(1, 32'hFFFF_FFFF); step("R6");
        read_all("R6 unchanged");
        // R5: main word write spares summary bits
        wr(0, 32'hFFFF_FFFF); step("R5");
        check("R5 main word", m_pend[0], 32'hC000_0000); read_all("R5 readback");
        // R7: emptying high word drops bit 31
        wr(2, 32'h8000_0000); step("R7");
        check("R7 bit31 cleared", m_pend[0], 32'h4000_0000); read_all("R7 readback");
        check("R7 line C low", 32'(irq_out), 32'h0);
        // R8: internal clear empties middle word, bit 30 drops
        ev_clr(32 + 7); step("R8");
        check("R8 all empty", m_pend[0] | m_pend[1], 32'h0); read_all("R8 readback");
        // R11: set and clear of one bit, set wins
        ev_set(64 + 4); ev_clr(64 + 4); step("R11");
        check("R11 high bit4", m_pend[2], 32'h10);
        check("R11 summary", 32'(m_pend[0][31]), 32'h1); read_all("R11 readback");
        // R12: unmapped slots ignore writes and read zero
        wr(3, 32'hFFFF_FFFF); step("R12");
        wr(7, 32'hFFFF_FFFF); step("R12");
        read_all("R12 map");

        // Random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(1, 0) != 0) ev_set($urandom_range(127, 0));
            if ($urandom_range(1, 0) != 0) begin
                if ($urandom_range(3, 0) == 0) ev_clr(int'(evt_set_num));
                else ev_clr($urandom_range(127, 0));
            end
            if ($urandom_range(9, 0) < 3)
                wr($urandom_range(15, 0), $urandom() & $urandom() & $urandom());
            step("R1 random");
            if (i % 8 == 0) read_all("R12 random readback");
        end
        finish_run();
    end
endmodule